// File: doc/BRIEF.md
# Stereo Audio Serial Port Master

This block drives the serial audio link of an external codec that runs as a clock slave. It runs entirely on the master clock (MCLK). From it, the block derives the bit clock (SCLK) and the left/right frame clock (LRCK). It shifts a stereo pair of PCM words out on the DAC data line. In the same frame, it collects the codec's ADC data line back into a parallel stereo pair.

A frame lasts exactly 256 MCLK cycles, so the sample rate is MCLK/256. Each frame holds 64 bit clocks, 32 for each channel slot. Four framing formats share one frame timing engine: standard I2S, left-justified, right-justified and DSP/PCM.

Upstream logic offers a sample pair with a valid/ready handshake. The block takes a pair, and the format select, only at the frame boundary. When no new pair is offered, it keeps sending the last pair.

The timing engine is a two-state machine, HALF_LEFT and HALF_RIGHT, plus an MCLK counter inside the half-frame:

- At the last MCLK cycle of the left slot, HALF_LEFT moves to HALF_RIGHT.
- At the last MCLK cycle of the right slot, HALF_RIGHT moves back to HALF_LEFT. That cycle is also the frame boundary, where `in_ready` is high.

SCLK_DIV and SLOT_BITS must be powers of two, and SCLK_DIV must be at least 2.

Top module: `pcm_link`

## Requirements
- R1: While reset is held, `sclk_o`, `lrck_o`, `sdata_o`, `in_ready` and `adc_valid` are all 0.
- R2: SCLK has a period of SCLK_DIV (4) MCLK cycles, and one frame spans 64 SCLK periods, which is 256 MCLK cycles.
- R3: Outside DSP mode, LRCK is low for the left slot (32 bit clocks) and high for the right slot (32 bit clocks). LRCK and the DAC data change only where SCLK falls.
- R4: With `fmt_sel`=2'b00 (standard I2S), the word MSB is valid at the second SCLK rising edge after an LRCK transition. The 16 bits follow MSB first, down to the LSB.
- R5: With `fmt_sel`=2'b01 (left-justified), the MSB is valid at the first SCLK rising edge of the slot, and the bits follow MSB first.
- R6: With `fmt_sel`=2'b10 (right-justified), the LSB is valid at the 32nd (last) SCLK rising edge of the slot, and the word is sent MSB first.
- R7: With `fmt_sel`=2'b11 (DSP), LRCK is high for exactly the first bit clock of the frame. The left MSB is valid at the second rising edge of the frame, and the right word follows the left LSB with no gap.
- R8: In every bit clock that carries no word bit, `sdata_o` is 0.
- R9: `in_ready` is a one-MCLK pulse once per frame. A pair accepted in that cycle is sent in the next frame. If no pair is accepted, the previous pair is sent again.
- R10: `fmt_sel` takes effect only at the frame boundary. A change in the middle of a frame leaves that frame unchanged.
- R11: `adc_sd` is sampled while SCLK is high, with the same bit positions as the selected format. Each captured pair appears on `adc_left`/`adc_right` with a one-MCLK `adc_valid` pulse, shortly after the frame ends.
- R12: `in_valid` asserted while `in_ready` is low has no effect on the transmitted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| in_valid | input | 1 | Sample pair offered |
| in_left | input | WORD_W | Left DAC word |
| in_right | input | WORD_W | Right DAC word |
| in_ready | output | 1 | Frame boundary; the pair is taken this cycle |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock / DSP frame pulse |
| sdata_o | output | 1 | Serial DAC data |
| adc_sd | input | 1 | Serial ADC data from the codec |
| adc_left | output | WORD_W | Captured left ADC word |
| adc_right | output | WORD_W | Captured right ADC word |
| adc_valid | output | 1 | Captured pair updated |

## Verification
The bench uses the defaults: WORD_W=16, SLOT_BITS=32 and SCLK_DIV=4. These give a 256-MCLK frame in which a 16-bit word leaves idle bit clocks in each slot. That makes the zero fill, the one-bit I2S delay and the right-justified placement each visible at different positions of the same 32-bit slot. A bench-side codec model decodes every bit clock of a frame, in each of the four formats. It also drives ADC bits on the falling SCLK edges, so the capture path is checked with the same positions it uses for transmit.

// File: rtl/pcm_link_pkg.sv
`timescale 1ns/1ps
package pcm_link_pkg;
    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef enum logic {
        HALF_LEFT  = 1'b0,
        HALF_RIGHT = 1'b1
    } half_e;
endpackage

// File: rtl/pcm_frame_seq.sv
`timescale 1ns/1ps
module pcm_frame_seq
    import pcm_link_pkg::*;
#(
    parameter  int WORD_W    = 16,
    parameter  int SLOT_BITS = 32,
    parameter  int SCLK_DIV  = 4,
    localparam int HALF_CNT  = SLOT_BITS * SCLK_DIV,
    localparam int CW        = $clog2(HALF_CNT),
    localparam int PHW       = $clog2(SCLK_DIV),
    localparam int IDW       = $clog2(WORD_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     fmt_sel,
    output logic [PHW-1:0] phase,
    output logic           frame_last,
    output logic           bit_hit,
    output logic           bit_ch,
    output logic [IDW-1:0] bit_idx,
    output logic           lrck_val
);
    half_e          half_q, half_d;
    logic [CW-1:0]  cnt_q;
    fmt_e           fmt_q;
    logic           at_end;

    assign at_end     = (cnt_q == CW'(HALF_CNT - 1));
    assign frame_last = at_end && (half_q == HALF_RIGHT);
    assign phase      = cnt_q[PHW-1:0];

    // next-state logic
    always_comb begin
        half_d = half_q;
        unique case (half_q)
            HALF_LEFT:  if (at_end) half_d = HALF_RIGHT;
            HALF_RIGHT: if (at_end) half_d = HALF_LEFT;
        endcase
    end

    // state register with in-slot counter and format latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= HALF_LEFT;
            cnt_q  <= '0;
            fmt_q  <= FMT_I2S;
        end else begin
            half_q <= half_d;
            cnt_q  <= at_end ? '0 : cnt_q + 1'b1;
            if (frame_last) fmt_q <= fmt_e'(fmt_sel);
        end
    end

    // outputs: slot position to word bit mapping per format
    always_comb begin
        int p;
        int g;
        int idx;
        p        = int'(cnt_q[CW-1:PHW]);
        g        = (half_q == HALF_RIGHT ? SLOT_BITS : 0) + p;
        bit_hit  = 1'b0;
        bit_ch   = (half_q == HALF_RIGHT);
        lrck_val = (half_q == HALF_RIGHT);
        idx      = 0;
        unique case (fmt_q)
            FMT_I2S: begin
                bit_hit = (p >= 1) && (p <= WORD_W);
                idx     = WORD_W - p;
            end
            FMT_LJ: begin
                bit_hit = (p < WORD_W);
                idx     = WORD_W - 1 - p;
            end
            FMT_RJ: begin
                bit_hit = (p >= SLOT_BITS - WORD_W);
                idx     = SLOT_BITS - 1 - p;
            end
            FMT_DSP: begin
                lrck_val = (g == 0);
                bit_hit  = (g >= 1) && (g <= 2 * WORD_W);
                bit_ch   = (g > WORD_W);
                idx      = bit_ch ? (2 * WORD_W - g) : (WORD_W - g);
            end
        endcase
        bit_idx = IDW'(idx);
    end
endmodule

// File: rtl/pcm_tx_ser.sv
`timescale 1ns/1ps
module pcm_tx_ser #(
    parameter  int WORD_W   = 16,
    parameter  int SCLK_DIV = 4,
    localparam int PHW      = $clog2(SCLK_DIV),
    localparam int IDW      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHW-1:0]    phase,
    input  logic              frame_last,
    input  logic              bit_hit,
    input  logic              bit_ch,
    input  logic [IDW-1:0]    bit_idx,
    input  logic              lrck_val,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    output logic              sclk_o,
    output logic              lrck_o,
    output logic              sdata_o
);
    logic [WORD_W-1:0] left_q, right_q, word;

    assign word = bit_ch ? right_q : left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            sclk_o  <= 1'b0;
            lrck_o  <= 1'b0;
            sdata_o <= 1'b0;
        end else begin
            if (frame_last && in_valid) begin
                left_q  <= in_left;
                right_q <= in_right;
            end
            sclk_o <= (phase >= PHW'(SCLK_DIV / 2));
            if (phase == '0) begin
                lrck_o  <= lrck_val;
                sdata_o <= bit_hit ? word[bit_idx] : 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcm_rx_deser.sv
`timescale 1ns/1ps
module pcm_rx_deser #(
    parameter  int WORD_W   = 16,
    parameter  int SCLK_DIV = 4,
    localparam int PHW      = $clog2(SCLK_DIV),
    localparam int IDW      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHW-1:0]    phase,
    input  logic              frame_last,
    input  logic              bit_hit,
    input  logic              bit_ch,
    input  logic [IDW-1:0]    bit_idx,
    input  logic              adc_sd,
    output logic [WORD_W-1:0] adc_left,
    output logic [WORD_W-1:0] adc_right,
    output logic              adc_valid
);
    logic [WORD_W-1:0] acc_l, acc_r;
    logic              frame_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_l      <= '0;
            acc_r      <= '0;
            frame_done <= 1'b0;
            adc_left   <= '0;
            adc_right  <= '0;
            adc_valid  <= 1'b0;
        end else begin
            if ((phase == PHW'(SCLK_DIV - 1)) && bit_hit) begin
                if (bit_ch) acc_r[bit_idx] <= adc_sd;
                else        acc_l[bit_idx] <= adc_sd;
            end
            frame_done <= frame_last;
            adc_valid  <= frame_done;
            if (frame_done) begin
                adc_left  <= acc_l;
                adc_right <= acc_r;
            end
        end
    end
endmodule

// File: rtl/pcm_link.sv
`timescale 1ns/1ps
module pcm_link #(
    parameter  int WORD_W    = 16,
    parameter  int SLOT_BITS = 32,
    parameter  int SCLK_DIV  = 4,
    localparam int PHW       = $clog2(SCLK_DIV),
    localparam int IDW       = $clog2(WORD_W)
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    output logic              in_ready,
    output logic              sclk_o,
    output logic              lrck_o,
    output logic              sdata_o,
    input  logic              adc_sd,
    output logic [WORD_W-1:0] adc_left,
    output logic [WORD_W-1:0] adc_right,
    output logic              adc_valid
);
    logic [PHW-1:0] phase;
    logic           frame_last, bit_hit, bit_ch, lrck_val;
    logic [IDW-1:0] bit_idx;

    assign in_ready = frame_last;

    pcm_frame_seq #(.WORD_W(WORD_W), .SLOT_BITS(SLOT_BITS), .SCLK_DIV(SCLK_DIV)) u_seq (
        .clk(mclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .phase(phase),
        .frame_last(frame_last), .bit_hit(bit_hit), .bit_ch(bit_ch),
        .bit_idx(bit_idx), .lrck_val(lrck_val)
    );

    pcm_tx_ser #(.WORD_W(WORD_W), .SCLK_DIV(SCLK_DIV)) u_tx (
        .clk(mclk), .rst_n(rst_n), .phase(phase), .frame_last(frame_last),
        .bit_hit(bit_hit), .bit_ch(bit_ch), .bit_idx(bit_idx), .lrck_val(lrck_val),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
    );

    pcm_rx_deser #(.WORD_W(WORD_W), .SCLK_DIV(SCLK_DIV)) u_rx (
        .clk(mclk), .rst_n(rst_n), .phase(phase), .frame_last(frame_last),
        .bit_hit(bit_hit), .bit_ch(bit_ch), .bit_idx(bit_idx), .adc_sd(adc_sd),
        .adc_left(adc_left), .adc_right(adc_right), .adc_valid(adc_valid)
    );
endmodule

// File: rtl/pcm_link_chk.sv
`timescale 1ns/1ps
module pcm_link_chk #(
    parameter int SCLK_DIV = 4
) (
    input logic mclk,
    input logic rst_n,
    input logic sclk_o,
    input logic lrck_o,
    input logic sdata_o,
    input logic in_ready,
    input logic adc_valid
);
    logic       sclk_d, seen_rise, rise;
    logic [7:0] since_rise;

    assign rise = sclk_o && !sclk_d;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (rise) begin
                seen_rise  <= 1'b1;
                since_rise <= 8'd1;
            end else if (since_rise != 8'hFF) begin
                since_rise <= since_rise + 8'd1;
            end
        end
    end

    a_r1_reset_quiet: assert property (@(posedge mclk)
        !rst_n |-> (!sclk_o && !lrck_o && !sdata_o && !in_ready && !adc_valid));

    a_r2_sclk_period: assert property (@(posedge mclk) disable iff (!rst_n)
        (rise && seen_rise) |-> (since_rise == 8'(SCLK_DIV)));

    a_r3_lrck_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(lrck_o) |-> $fell(sclk_o));

    a_r8_data_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $fell(sclk_o));

    a_r9_ready_pulse: assert property (@(posedge mclk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    a_r11_valid_pulse: assert property (@(posedge mclk) disable iff (!rst_n)
        adc_valid |=> !adc_valid);
endmodule

bind pcm_link pcm_link_chk #(.SCLK_DIV(SCLK_DIV)) u_chk (
    .mclk(mclk), .rst_n(rst_n), .sclk_o(sclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o), .in_ready(in_ready), .adc_valid(adc_valid)
);

// File: tb/tb_pcm_link.sv
`timescale 1ns/1ps
module tb_pcm_link;
    localparam logic [1:0] F_I2S = 2'b00, F_LJ = 2'b01, F_RJ = 2'b10, F_DSP = 2'b11;

    logic        mclk = 1'b0;
    logic        rst_n = 1'b1;
    logic [1:0]  fmt_sel = F_I2S;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0, in_right = '0;
    logic        in_ready, sclk_o, lrck_o, sdata_o;
    logic        adc_sd = 1'b0;
    logic [15:0] adc_left, adc_right;
    logic        adc_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 mclk = ~mclk;

    pcm_link dut (
        .mclk(mclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .in_ready(in_ready),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o), .adc_sd(adc_sd),
        .adc_left(adc_left), .adc_right(adc_right), .adc_valid(adc_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected serial bit at bit clock k (0..63) of a frame
    function automatic logic exp_bit(input logic [1:0] f, input int k, input logic [15:0] l, input logic [15:0] r);
        int p;
        logic [15:0] w;
        p = k % 32;
        w = (k >= 32) ? r : l;
        case (f)
            F_I2S:   return (p >= 1 && p <= 16) ? w[16 - p] : 1'b0;
            F_LJ:    return (p <= 15) ? w[15 - p] : 1'b0;
            F_RJ:    return (p >= 16) ? w[31 - p] : 1'b0;
            default: begin
                if (k >= 1 && k <= 16)  return l[16 - k];
                if (k >= 17 && k <= 32) return r[32 - k];
                return 1'b0;
            end
        endcase
    endfunction

    function automatic logic exp_lr(input logic [1:0] f, input int k);
        return (f == F_DSP) ? (k == 0) : (k >= 32);
    endfunction

    task automatic send_pair(input logic [1:0] f, input logic [15:0] l, input logic [15:0] r);
        @(negedge mclk);
        while (!in_ready) @(negedge mclk);
        fmt_sel  = f;
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        @(negedge mclk);
        in_valid = 1'b0;
    endtask

    // codec model: decode one frame of format f, drive ADC bits, then check it all
    task automatic run_frame(input logic [1:0] f, input logic [15:0] l, input logic [15:0] r,
                             input logic [15:0] al, input logic [15:0] ar,
                             input int sw_k, input logic [1:0] sw_f, input string tag);
        logic        ps, pl;
        logic [63:0] got_d, got_lr, exp_d, exp_lrv;
        int          k, mclks;
        bit          found;
        got_d = '0; got_lr = '0;
        ps = sclk_o; pl = lrck_o; found = 0;
        while (!found) begin
            @(negedge mclk);
            if ((f == F_DSP) ? (!pl && lrck_o) : (pl && !lrck_o)) found = 1;
            pl = lrck_o;
        end
        k = 0; mclks = 0;
        adc_sd = exp_bit(f, 0, al, ar);
        ps = sclk_o;
        while (k < 64) begin
            @(negedge mclk);
            mclks++;
            if (!ps && sclk_o) begin
                got_d[63 - k]  = sdata_o;
                got_lr[63 - k] = lrck_o;
            end
            if (ps && !sclk_o) begin
                k++;
                if (k == sw_k) fmt_sel = sw_f;
                if (k < 64) adc_sd = exp_bit(f, k, al, ar);
            end
            ps = sclk_o;
        end
        for (int i = 0; i < 64; i++) begin
            exp_d[63 - i]   = exp_bit(f, i, l, r);
            exp_lrv[63 - i] = exp_lr(f, i);
        end
        chk(got_d == exp_d, {tag, " R8 data bits"}, got_d, exp_d);
        chk(got_lr == exp_lrv, {tag, " R3 lrck per bit"}, got_lr, exp_lrv);
        chk(mclks == 256, {tag, " R2 frame length"}, 64'(mclks), 64'd256);
        chk(adc_valid === 1'b1, {tag, " R11 adc_valid"}, 64'(adc_valid), 64'd1);
        chk({adc_left, adc_right} == {al, ar}, {tag, " R11 adc words"},
            64'({adc_left, adc_right}), 64'({al, ar}));
    endtask

    task automatic t_reset();
        @(negedge mclk);
        chk({sclk_o, lrck_o, sdata_o, in_ready, adc_valid} == 5'b0, "R1 reset outputs",
            64'({sclk_o, lrck_o, sdata_o, in_ready, adc_valid}), 64'd0);
    endtask

    task automatic t_i2s();
        send_pair(F_I2S, 16'hA5C3, 16'h3C5A);
        run_frame(F_I2S, 16'hA5C3, 16'h3C5A, 16'h8001, 16'h7FFE, -1, F_I2S, "R4 i2s");
    endtask

    task automatic t_lj();
        send_pair(F_LJ, 16'h8421, 16'hF00F);
        run_frame(F_LJ, 16'h8421, 16'hF00F, 16'h1234, 16'hFEDC, -1, F_LJ, "R5 lj");
    endtask

    task automatic t_rj();
        send_pair(F_RJ, 16'h0001, 16'hC003);
        run_frame(F_RJ, 16'h0001, 16'hC003, 16'hB00B, 16'h0F0F, -1, F_RJ, "R6 rj");
    endtask

    task automatic t_dsp();
        send_pair(F_DSP, 16'hFFFF, 16'h8001);
        run_frame(F_DSP, 16'hFFFF, 16'h8001, 16'h5A5A, 16'hA5A5, -1, F_DSP, "R7 dsp");
    endtask

    task automatic t_repeat();
        send_pair(F_I2S, 16'h1357, 16'h9BDF);
        run_frame(F_I2S, 16'h1357, 16'h9BDF, 16'h0000, 16'hFFFF, -1, F_I2S, "R9 first");
        run_frame(F_I2S, 16'h1357, 16'h9BDF, 16'h4321, 16'h8765, -1, F_I2S, "R9 repeat");
    endtask

    task automatic t_ignore();
        send_pair(F_LJ, 16'h6E6E, 16'h1111);
        run_frame(F_LJ, 16'h6E6E, 16'h1111, 16'h2222, 16'h3333, -1, F_LJ, "R12 base");
        repeat (40) @(negedge mclk);
        chk(in_ready == 1'b0, "R12 not ready mid frame", 64'(in_ready), 64'd0);
        in_valid = 1'b1; in_left = 16'hDEAD; in_right = 16'hBEEF;
        @(negedge mclk);
        in_valid = 1'b0;
        run_frame(F_LJ, 16'h6E6E, 16'h1111, 16'h4444, 16'h5555, -1, F_LJ, "R12 ignored");
    endtask

    task automatic t_fmt_hold();
        send_pair(F_I2S, 16'h7001, 16'h0E0E);
        run_frame(F_I2S, 16'h7001, 16'h0E0E, 16'h6666, 16'h7777, 20, F_LJ, "R10 mid change");
        run_frame(F_LJ, 16'h7001, 16'h0E0E, 16'h9999, 16'hAAAA, -1, F_LJ, "R10 next frame");
    endtask

    task automatic t_ready_gap();
        int gap, width;
        @(negedge mclk);
        while (!in_ready) @(negedge mclk);
        width = 0;
        while (in_ready) begin width++; @(negedge mclk); end
        gap = 1;
        while (!in_ready) begin gap++; @(negedge mclk); end
        chk(width == 1, "R9 ready width", 64'(width), 64'd1);
        chk(gap == 256, "R9 ready spacing", 64'(gap), 64'd256);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge mclk);
        t_reset();
        @(negedge mclk);
        rst_n = 1'b1;
        t_i2s();
        t_lj();
        t_rj();
        t_dsp();
        t_repeat();
        t_ignore();
        t_fmt_hold();
        t_ready_gap();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule